// File: doc/BRIEF.md
# Multi-Lane Serial Flash Command Front End

This block is the target-side serial front end of a flash device. It watches chip select, the serial clock and four data lanes, and shifts in an instruction byte, then a 24-bit address and, for reads, shifts a data byte back out. Three bus protocols are supported, and only one is active at a time: extended (instruction on one lane, address and data on one, two or four lanes as the instruction selects), dual (every phase on two lanes) and quad (every phase on four lanes).

The active protocol is held as a small state. On reset, which stands for power-up, it is loaded from a non-volatile configuration byte. It then changes only when a complete volatile-configuration write command ends, and every command after that uses the new lane count. Any command cut short by chip select going high is dropped, and it leaves that state unchanged. Decoded commands leave the block as an opcode, an address and a one-cycle strobe. The read byte comes from the storage side on an input port.

Top module: `spi_fe_top`

## Requirements
- R1: During and after reset, `proto` is 2 (quad) when `nv_cfg[3]` is 0, otherwise 1 (dual) when `nv_cfg[2]` is 0, otherwise 0 (extended), and `dq_oe` is 0.
- R2: In extended protocol the instruction is taken MSB first on DQ0 alone, one bit per rising clock edge.
- R3: In extended protocol, opcode 0x03 carries address and read data on one lane, 0xBB on two lanes, 0xEB on four lanes, and 0x02 carries address and write data on one lane. With several lanes, the highest used lane carries the more significant bit of each group.
- R4: In dual protocol, the instruction, address and data all use DQ1:DQ0 for every addressed opcode.
- R5: In quad protocol, the instruction, address and data all use DQ3:DQ0 for every addressed opcode.
- R6: Inputs are sampled on rising clock edges and outputs change after falling edges, whether the clock idles low or high while chip select is high.
- R7: `cmd_opcode` takes the instruction once all 8 of its bits are in. After the last address bit of an addressed opcode, `cmd_addr` takes the address and `cmd_valid` pulses for exactly one cycle.
- R8: A read returns `rd_byte` MSB first, repeating it for each byte, starting on the falling edge after the last address bit. A single-lane read drives DQ1 only, so `dq_oe` is 0010. Two lanes give 0011 and four lanes give 1111.
- R9: Opcode 0x61 followed by a full data byte sets the protocol when chip select rises: bit 7 clear selects quad, otherwise bit 6 clear selects dual, otherwise extended. Later commands use the new lane count.
- R10: Chip select high aborts any partial command, returns all lanes to high impedance, and leaves the protocol unchanged. A configuration write with fewer than 8 data bits has no effect.
- R11: A reset discards any protocol set by a volatile write and restores the protocol given by `nv_cfg`.
- R12: An opcode outside the set above produces no `cmd_valid` and drives no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| nv_cfg | input | 8 | Non-volatile configuration byte; bits 3 and 2 select the power-up protocol |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| dq_in | input | 4 | Pin values of data lanes DQ3..DQ0 |
| rd_byte | input | 8 | Byte returned during read data phases |
| dq_out | output | 4 | Values driven onto DQ3..DQ0 |
| dq_oe | output | 4 | Per-lane output enable; 0 means high impedance |
| proto | output | 2 | Active protocol: 0 extended, 1 dual, 2 quad |
| cmd_opcode | output | 8 | Last complete instruction byte |
| cmd_addr | output | 24 | Last complete address |
| cmd_valid | output | 1 | One-cycle strobe when an address phase completes |

## Verification
If the protocol state is wrong, the very next instruction is shifted at the wrong lane count. The opcode and address then come out scrambled, and `cmd_valid` appears at the wrong edge or not at all, all within the first command after the bad state. A lane counter or phase register that is off by one shows up in the read byte rebuilt from DQ on the next falling edge, or as an output enable pattern outside the three legal ones. A configuration write that commits when it should not, or fails to commit, shows up at once on `proto` and in the lane count of the following command.

// File: rtl/spi_fe_pkg.sv
// Package for the serial flash front end: protocol and phase types,
// opcode codes and the lane count helper shared by all submodules.
package spi_fe_pkg;

    typedef enum logic [1:0] {
        PROTO_EXT  = 2'd0,
        PROTO_DUAL = 2'd1,
        PROTO_QUAD = 2'd2
    } proto_e;

    typedef enum logic [2:0] {
        PH_CMD    = 3'd0,
        PH_ADDR   = 3'd1,
        PH_WCFG   = 3'd2,
        PH_RDATA  = 3'd3,
        PH_IGNORE = 3'd4
    } phase_e;

    localparam logic [7:0] OP_RD1  = 8'h03;
    localparam logic [7:0] OP_RD2  = 8'hBB;
    localparam logic [7:0] OP_RD4  = 8'hEB;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_WCFG = 8'h61;

    // Number of lanes that carry the instruction under a given protocol.
    function automatic logic [2:0] lanes_of(input proto_e p);
        case (p)
            PROTO_DUAL: lanes_of = 3'd2;
            PROTO_QUAD: lanes_of = 3'd4;
            default:    lanes_of = 3'd1;
        endcase
    endfunction

    // True for opcodes that return read data.
    function automatic logic is_read_op(input logic [7:0] op);
        is_read_op = (op == OP_RD1) || (op == OP_RD2) || (op == OP_RD4);
    endfunction

endpackage

// File: rtl/spi_fe_sampler.sv
// Pin sampler: brings chip select, serial clock and the data lanes into
// the system clock domain through a chain of STAGES flops and derives
// single-cycle rising/falling clock events, gated by chip select.
// Assumes clk runs several times faster than the serial clock so that
// every serial edge is seen as a level change between two samples.
module spi_fe_sampler #(
    parameter int STAGES = 2,
    parameter int LANES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck,
    input  logic [LANES-1:0] dq,
    output logic             rise_ev,
    output logic             fall_ev,
    output logic             cs_hi,
    output logic             cs_rise_ev,
    output logic [LANES-1:0] dq_s
);
    localparam int PW = LANES + 2;
    localparam logic [PW-1:0] PIPE_RST = {1'b1, {(PW-1){1'b0}}};

    logic [PW-1:0] pipe [STAGES];
    logic          sck_prev;
    logic          cs_prev;

    // First stage captures the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= PIPE_RST;
        else        pipe[0] <= {cs_n, sck, dq};
    end

    // Remaining stages of the synchronizer chain.
    for (genvar i = 1; i < STAGES; i++) begin : g_sync
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[i] <= PIPE_RST;
            else        pipe[i] <= pipe[i-1];
        end
    end

    // Previous synchronized clock and select levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev <= 1'b0;
            cs_prev  <= 1'b1;
        end else begin
            sck_prev <= pipe[STAGES-1][LANES];
            cs_prev  <= pipe[STAGES-1][LANES+1];
        end
    end

    // Decode events from the synchronized levels.
    always_comb begin
        cs_hi      = pipe[STAGES-1][LANES+1];
        dq_s       = pipe[STAGES-1][LANES-1:0];
        rise_ev    = !cs_hi &&  pipe[STAGES-1][LANES] && !sck_prev;
        fall_ev    = !cs_hi && !pipe[STAGES-1][LANES] &&  sck_prev;
        cs_rise_ev = cs_hi && !cs_prev;
    end

endmodule

// File: rtl/spi_fe_mode.sv
// Protocol state: loaded from the non-volatile byte while reset is held,
// replaced by the volatile byte when a complete configuration write
// commits. Quad has priority over dual in both decodes.
module spi_fe_mode
    import spi_fe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] nv_cfg,
    input  logic       cfg_wr,
    input  logic [7:0] cfg_byte,
    output proto_e     proto_st
);
    logic unused_bits;
    assign unused_bits = ^{nv_cfg[7:4], nv_cfg[1:0], cfg_byte[5:0]};

    // Non-volatile decode: bit 3 low selects quad, bit 2 low selects dual.
    function automatic proto_e nv_decode(input logic [7:0] b);
        if (!b[3])      nv_decode = PROTO_QUAD;
        else if (!b[2]) nv_decode = PROTO_DUAL;
        else            nv_decode = PROTO_EXT;
    endfunction

    // Volatile decode: bit 7 low selects quad, bit 6 low selects dual.
    function automatic proto_e vol_decode(input logic [7:0] b);
        if (!b[7])      vol_decode = PROTO_QUAD;
        else if (!b[6]) vol_decode = PROTO_DUAL;
        else            vol_decode = PROTO_EXT;
    endfunction

    // Hold the protocol; reset restores the non-volatile choice.
    always_ff @(posedge clk) begin
        if (!rst_n)      proto_st <= nv_decode(nv_cfg);
        else if (cfg_wr) proto_st <= vol_decode(cfg_byte);
    end

endmodule

// File: rtl/spi_fe_engine.sv
// Lane engine: shifts the instruction, address and configuration data in
// on rising events at the lane count of the current phase, and shifts
// read data out on falling events. Chip select high clears all phase
// state; a full configuration byte commits on the chip select rise.
// Assumes ADDR_W is a multiple of 4.
module spi_fe_engine
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              cs_hi,
    input  logic              cs_rise_ev,
    input  logic [LANES-1:0]  dq_s,
    input  proto_e            proto_st,
    input  logic [7:0]        rd_byte,
    output logic [7:0]        cmd_opcode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_valid,
    output logic              cfg_wr,
    output logic [7:0]        cfg_byte,
    output logic [LANES-1:0]  dq_out,
    output logic [LANES-1:0]  dq_oe
);
    localparam int CNT_W = $clog2(ADDR_W + 8) + 1;
    localparam logic [CNT_W-1:0] CNT_BYTE = CNT_W'(8);
    localparam logic [CNT_W-1:0] CNT_ADDR = CNT_W'(ADDR_W);

    phase_e             phase;
    logic [CNT_W-1:0]   bitcnt;
    logic [ADDR_W-1:0]  shreg;
    logic [7:0]         opcode_q;
    logic [2:0]         xw;
    logic [7:0]         osh;
    logic [2:0]         ocnt;
    logic               wcfg_full;

    logic [2:0]         w_now;
    logic [LANES-1:0]   nib;
    logic [ADDR_W-1:0]  shifted;
    logic [CNT_W-1:0]   next_cnt;
    phase_e             dec_phase;
    logic [2:0]         dec_w;
    logic [7:0]         src;

    // Lane count of the current phase and the shifted-in value.
    always_comb begin
        w_now = (phase == PH_CMD) ? lanes_of(proto_st) : xw;
        case (w_now)
            3'd1:    nib = {{(LANES-1){1'b0}}, dq_s[0]};
            3'd2:    nib = {{(LANES-2){1'b0}}, dq_s[1:0]};
            default: nib = dq_s;
        endcase
        shifted  = (shreg << w_now) | {{(ADDR_W-LANES){1'b0}}, nib};
        next_cnt = bitcnt + CNT_W'(w_now);
    end

    // Decode the completing instruction into the next phase and lane count.
    always_comb begin
        dec_phase = PH_IGNORE;
        dec_w     = lanes_of(proto_st);
        case (shifted[7:0])
            OP_RD1, OP_RD2, OP_RD4, OP_PROG: dec_phase = PH_ADDR;
            OP_WCFG:                         dec_phase = PH_WCFG;
            default:                         dec_phase = PH_IGNORE;
        endcase
        if (proto_st == PROTO_EXT) begin
            case (shifted[7:0])
                OP_RD2:  dec_w = 3'd2;
                OP_RD4:  dec_w = 3'd4;
                default: dec_w = 3'd1;
            endcase
        end
    end

    // Source byte for the next read output group.
    always_comb src = (ocnt == 3'd0) ? rd_byte : osh;

    // Phase sequencing, input shifting and read output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_CMD;
            bitcnt     <= '0;
            shreg      <= '0;
            opcode_q   <= 8'h00;
            xw         <= 3'd1;
            osh        <= 8'h00;
            ocnt       <= 3'd0;
            wcfg_full  <= 1'b0;
            cmd_opcode <= 8'h00;
            cmd_addr   <= '0;
            cmd_valid  <= 1'b0;
            cfg_wr     <= 1'b0;
            cfg_byte   <= 8'hFF;
            dq_out     <= '0;
            dq_oe      <= '0;
        end else if (cs_hi) begin
            phase     <= PH_CMD;
            bitcnt    <= '0;
            shreg     <= '0;
            ocnt      <= 3'd0;
            wcfg_full <= 1'b0;
            cmd_valid <= 1'b0;
            cfg_wr    <= cs_rise_ev && wcfg_full;
            cfg_byte  <= shreg[7:0];
            dq_out    <= '0;
            dq_oe     <= '0;
        end else begin
            cmd_valid <= 1'b0;
            cfg_wr    <= 1'b0;
            if (rise_ev) begin
                case (phase)
                    PH_CMD: begin
                        shreg <= shifted;
                        if (next_cnt == CNT_BYTE) begin
                            bitcnt     <= '0;
                            opcode_q   <= shifted[7:0];
                            cmd_opcode <= shifted[7:0];
                            phase      <= dec_phase;
                            xw         <= dec_w;
                        end else begin
                            bitcnt <= next_cnt;
                        end
                    end
                    PH_ADDR: begin
                        shreg <= shifted;
                        if (next_cnt == CNT_ADDR) begin
                            bitcnt    <= '0;
                            cmd_addr  <= shifted;
                            cmd_valid <= 1'b1;
                            phase     <= is_read_op(opcode_q) ? PH_RDATA : PH_IGNORE;
                        end else begin
                            bitcnt <= next_cnt;
                        end
                    end
                    PH_WCFG: begin
                        shreg <= shifted;
                        if (next_cnt == CNT_BYTE) begin
                            bitcnt    <= '0;
                            wcfg_full <= 1'b1;
                            phase     <= PH_IGNORE;
                        end else begin
                            bitcnt <= next_cnt;
                        end
                    end
                    default: ;
                endcase
            end
            if (fall_ev && phase == PH_RDATA) begin
                case (xw)
                    3'd1: begin
                        dq_out <= {{(LANES-2){1'b0}}, src[7], 1'b0};
                        dq_oe  <= {{(LANES-2){1'b0}}, 2'b10};
                    end
                    3'd2: begin
                        dq_out <= {{(LANES-2){1'b0}}, src[7:6]};
                        dq_oe  <= {{(LANES-2){1'b0}}, 2'b11};
                    end
                    default: begin
                        dq_out <= src[7:8-LANES];
                        dq_oe  <= '1;
                    end
                endcase
                osh  <= src << xw;
                ocnt <= ocnt + xw;
            end
        end
    end

endmodule

// File: rtl/spi_fe_top.sv
// Top of the serial flash front end: pin sampler, protocol state and
// lane engine. Presents the decoded command and the per-lane drive.
module spi_fe_top
    import spi_fe_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        nv_cfg,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic [3:0]        dq_in,
    input  logic [7:0]        rd_byte,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    output logic [1:0]        proto,
    output logic [7:0]        cmd_opcode,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_valid
);
    localparam int LANES = 4;

    logic             rise_ev;
    logic             fall_ev;
    logic             cs_hi;
    logic             cs_rise_ev;
    logic [LANES-1:0] dq_s;
    logic             cfg_wr;
    logic [7:0]       cfg_byte;
    proto_e           proto_st;

    spi_fe_sampler #(.STAGES(STAGES), .LANES(LANES)) u_smp (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (spi_cs_n),
        .sck        (spi_sck),
        .dq         (dq_in),
        .rise_ev    (rise_ev),
        .fall_ev    (fall_ev),
        .cs_hi      (cs_hi),
        .cs_rise_ev (cs_rise_ev),
        .dq_s       (dq_s)
    );

    spi_fe_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .nv_cfg   (nv_cfg),
        .cfg_wr   (cfg_wr),
        .cfg_byte (cfg_byte),
        .proto_st (proto_st)
    );

    spi_fe_engine #(.ADDR_W(ADDR_W), .LANES(LANES)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_ev    (rise_ev),
        .fall_ev    (fall_ev),
        .cs_hi      (cs_hi),
        .cs_rise_ev (cs_rise_ev),
        .dq_s       (dq_s),
        .proto_st   (proto_st),
        .rd_byte    (rd_byte),
        .cmd_opcode (cmd_opcode),
        .cmd_addr   (cmd_addr),
        .cmd_valid  (cmd_valid),
        .cfg_wr     (cfg_wr),
        .cfg_byte   (cfg_byte),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    assign proto = proto_st;

endmodule

// File: rtl/spi_fe_chk.sv
// Checker for the serial flash front end, bound to spi_fe_top.
module spi_fe_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_hi,
    input logic       fall_ev,
    input logic       cmd_valid,
    input logic       cfg_wr,
    input logic [1:0] proto,
    input logic [3:0] dq_oe
);
    // R1
    proto_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        proto != 2'b11);

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8
    oe_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe == 4'b0000) || (dq_oe == 4'b0010) || (dq_oe == 4'b0011) || (dq_oe == 4'b1111));

    // R10
    deselect_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> (dq_oe == 4'b0000));

    // R6
    oe_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != $past(dq_oe)) |-> $past(fall_ev || cs_hi));

    // R9
    proto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(proto));

endmodule

bind spi_fe_top spi_fe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_hi     (cs_hi),
    .fall_ev   (fall_ev),
    .cmd_valid (cmd_valid),
    .cfg_wr    (cfg_wr),
    .proto     (proto),
    .dq_oe     (dq_oe)
);

// File: tb/sim_spi_fe_top.sv
`timescale 1ns/1ps
module sim_spi_fe_top;
    localparam int HALF = 6;
    localparam int NVEC = 10;

    // {cfg write, cfg byte, opcode, address, read byte, clock idles high}
    localparam logic [49:0] VEC [NVEC] = '{
        {1'b0, 8'h00, 8'h03, 24'h123456, 8'hA5, 1'b0},
        {1'b0, 8'h00, 8'hBB, 24'hABCDEF, 8'h3C, 1'b1},
        {1'b0, 8'h00, 8'hEB, 24'h00F00F, 8'h96, 1'b0},
        {1'b0, 8'h00, 8'h02, 24'h0055AA, 8'h00, 1'b1},
        {1'b1, 8'hBF, 8'h03, 24'hFEDCBA, 8'h5A, 1'b0},
        {1'b0, 8'h00, 8'hEB, 24'h102030, 8'hC3, 1'b1},
        {1'b1, 8'h7F, 8'h03, 24'h0A0B0C, 8'hE7, 1'b1},
        {1'b0, 8'h00, 8'hBB, 24'h777777, 8'h18, 1'b0},
        {1'b1, 8'hFF, 8'hBB, 24'h314159, 8'h81, 1'b0},
        {1'b0, 8'h00, 8'h9F, 24'h000000, 8'h00, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  nv_cfg = 8'hFF;
    logic        spi_cs_n = 1'b1;
    logic        spi_sck = 1'b0;
    logic [3:0]  dq_in = 4'h0;
    logic [7:0]  rd_byte = 8'h00;
    logic [3:0]  dq_out;
    logic [3:0]  dq_oe;
    logic [1:0]  proto;
    logic [7:0]  cmd_opcode;
    logic [23:0] cmd_addr;
    logic        cmd_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int vcnt = 0;
    int mproto = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_fe_top u0 (
        .clk(clk), .rst_n(rst_n), .nv_cfg(nv_cfg), .spi_cs_n(spi_cs_n),
        .spi_sck(spi_sck), .dq_in(dq_in), .rd_byte(rd_byte), .dq_out(dq_out),
        .dq_oe(dq_oe), .proto(proto), .cmd_opcode(cmd_opcode),
        .cmd_addr(cmd_addr), .cmd_valid(cmd_valid)
    );

    always @(posedge clk) if (rst_n && cmd_valid) vcnt++;

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int pw(input int p);
        return (p == 0) ? 1 : (p == 1) ? 2 : 4;
    endfunction

    function automatic int xwidth(input int p, input logic [7:0] op);
        if (p != 0) return pw(p);
        if (op == 8'hBB) return 2;
        if (op == 8'hEB) return 4;
        return 1;
    endfunction

    function automatic int nv_model(input logic [7:0] b);
        if (!b[3]) return 2;
        if (!b[2]) return 1;
        return 0;
    endfunction

    function automatic int vol_model(input logic [7:0] b);
        if (!b[7]) return 2;
        if (!b[6]) return 1;
        return 0;
    endfunction

    function automatic logic [3:0] oe_mask(input int w);
        return (w == 1) ? 4'b0010 : (w == 2) ? 4'b0011 : 4'b1111;
    endfunction

    task automatic do_reset(input logic [7:0] nv);
        rst_n = 1'b0; nv_cfg = nv; spi_cs_n = 1'b1; spi_sck = 1'b0;
        wclk(4);
        rst_n = 1'b1;
        wclk(4);
        mproto = nv_model(nv);
    endtask

    task automatic begin_tx(input bit m3);
        spi_sck = m3;
        wclk(HALF);
        spi_cs_n = 1'b0;
        wclk(HALF);
    endtask

    task automatic end_tx(input bit m3);
        if (!m3) begin
            spi_sck = 1'b0;
            wclk(HALF);
        end
        spi_cs_n = 1'b1;
        wclk(3 * HALF);
    endtask

    task automatic drive_bits(input logic [31:0] val, input int nbits, input int w);
        for (int k = 0; k < nbits / w; k++) begin
            logic [31:0] ch;
            ch = (val >> (nbits - w * (k + 1))) & ((32'd1 << w) - 1);
            spi_sck = 1'b0;
            dq_in = ch[3:0];
            wclk(HALF);
            spi_sck = 1'b1;
            wclk(HALF);
        end
    endtask

    task automatic read_bytes(input logic [7:0] exp, input int nbytes, input int w, input string req);
        for (int b = 0; b < nbytes; b++) begin
            logic [7:0] got;
            got = 8'h00;
            for (int k = 0; k < 8 / w; k++) begin
                spi_sck = 1'b0;
                dq_in = 4'h0;
                wclk(HALF);
                if (w == 1)      got = {got[6:0], dq_out[1]};
                else if (w == 2) got = {got[5:0], dq_out[1:0]};
                else             got = {got[3:0], dq_out};
                chk({req, " R8 oe"}, 32'(dq_oe), 32'(oe_mask(w)));
                spi_sck = 1'b1;
                wclk(HALF);
            end
            chk({req, " R8 data"}, 32'(got), 32'(exp));
        end
    endtask

    task automatic quiet_cycles(input int n);
        for (int k = 0; k < n; k++) begin
            spi_sck = 1'b0;
            dq_in = 4'h0;
            wclk(HALF);
            chk("R12 no drive", 32'(dq_oe), 32'h0);
            spi_sck = 1'b1;
            wclk(HALF);
        end
    endtask

    task automatic cfg_write(input logic [7:0] vb, input int nbits, input bit m3);
        int cw;
        int xw;
        cw = pw(mproto);
        xw = (mproto == 0) ? 1 : cw;
        begin_tx(m3);
        drive_bits(32'h61, 8, cw);
        drive_bits(32'(vb) >> (8 - nbits), nbits, xw);
        end_tx(m3);
        if (nbits == 8) mproto = vol_model(vb);
        chk("R9/R10 proto after config write", 32'(proto), 32'(mproto));
    endtask

    task automatic run_cmd(input logic [7:0] op, input logic [23:0] addr,
                           input logic [7:0] rd, input bit m3, input string req);
        int  cw;
        int  xw;
        int  v0;
        bit  addressed;
        bit  rdop;
        cw = pw(mproto);
        xw = xwidth(mproto, op);
        rdop = (op == 8'h03) || (op == 8'hBB) || (op == 8'hEB);
        addressed = rdop || (op == 8'h02);
        v0 = vcnt;
        rd_byte = rd;
        begin_tx(m3);
        drive_bits(32'(op), 8, cw);
        if (addressed) begin
            drive_bits(32'(addr), 24, xw);
            if (rdop) read_bytes(rd, 2, xw, req);
            else      drive_bits(32'h5A, 8, xw);
        end else begin
            quiet_cycles(8);
        end
        end_tx(m3);
        chk({req, " R2 opcode"}, 32'(cmd_opcode), 32'(op));
        if (addressed) chk({req, " R7 address"}, 32'(cmd_addr), 32'(addr));
        chk({req, " R7 one strobe"}, 32'(vcnt - v0), addressed ? 32'd1 : 32'd0);
        chk({req, " R10 idle release"}, 32'(dq_oe), 32'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state in extended protocol
        do_reset(8'hFF);
        chk("R1 proto nv=FF", 32'(proto), 32'd0);
        chk("R1 oe after reset", 32'(dq_oe), 32'h0);

        // Table walk: R3 extended lanes, R4 dual, R5 quad, R6 both idle levels, R9 writes
        for (int i = 0; i < NVEC; i++) begin
            logic [49:0] v;
            v = VEC[i];
            if (v[49]) cfg_write(v[48:41], 8, v[0]);
            run_cmd(v[40:33], v[32:9], v[8:1], v[0], $sformatf("vec%0d R3/R4/R5/R6", i));
        end

        // R1: non-volatile decode, quad has priority
        do_reset(8'hFB);
        chk("R1 proto nv=FB dual", 32'(proto), 32'd1);
        run_cmd(8'h03, 24'h2468AC, 8'h6D, 1'b1, "R4 dual read after reset");
        do_reset(8'hF7);
        chk("R1 proto nv=F7 quad", 32'(proto), 32'd2);
        run_cmd(8'h03, 24'h13579B, 8'hB2, 1'b0, "R5 quad read after reset");
        do_reset(8'hF3);
        chk("R1 proto nv=F3 quad priority", 32'(proto), 32'd2);

        // R9: both volatile bits clear selects quad
        do_reset(8'hFF);
        cfg_write(8'h3F, 8, 1'b0);
        chk("R9 quad priority", 32'(proto), 32'd2);
        run_cmd(8'hBB, 24'hC0FFEE, 8'h4E, 1'b0, "R9 quad follows write");

        // R11: reset drops volatile protocol
        do_reset(8'hFF);
        chk("R11 proto restored", 32'(proto), 32'd0);
        run_cmd(8'h03, 24'h000001, 8'h01, 1'b0, "R11 extended after reset");

        // R10: partial instruction aborted
        begin_tx(1'b0);
        drive_bits(32'h0B, 5, 1);
        end_tx(1'b0);
        chk("R10 proto after abort", 32'(proto), 32'd0);
        chk("R10 oe after abort", 32'(dq_oe), 32'h0);
        run_cmd(8'hEB, 24'hFACADE, 8'h99, 1'b1, "R10 command after abort");

        // R10: partial config write has no effect
        cfg_write(8'h3F, 4, 1'b0);
        chk("R10 partial write ignored", 32'(proto), 32'd0);
        run_cmd(8'h03, 24'h00BEEF, 8'h3A, 1'b0, "R10 extended kept");

        // R12: unknown opcode in quad protocol
        do_reset(8'hF7);
        run_cmd(8'hC7, 24'h0, 8'hFF, 1'b0, "R12 unknown in quad");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule